// File: doc/BRIEF.md
# Stereo Audio Capture Register Port

This block collects stereo audio samples into two independent receive queues, one for the left channel and one for the right. A bus master reaches them through a small word-addressed register window. Each channel delivers samples on its own valid/data strobe. The block counts how many samples each queue holds and reports both counts together in one occupancy word.

Software reads the occupancy word and waits until a fill threshold is crossed, for example more than 96 of 128 entries. It then drains both channels in lockstep. Each read of a channel's data register removes the oldest sample of that channel, and software reads the occupancy word again after every left/right pair.

Read data is registered. It appears on the cycle after the read strobe and stays there until the next read.

Top module: `audio_rx_port`

## Requirements
- R1: After a synchronous reset, both queue counts are zero and the read data output is zero.
- R2: A read of word 1 returns the occupancy word. Bits 7:0 hold the right-channel count and bits 15:8 hold the left-channel count, both taken in the cycle of the read strobe. The word is on the read data output one cycle after the strobe.
- R3: Bits 23:16 and 31:24 of the occupancy word always report the transmit free space of the right and left channel. Each equals the parameter TX_FREE, which is 128 by default, so bits 31:16 read 0x8080.
- R4: A read of word 2 removes and returns the oldest left sample, and a read of word 3 does the same for the right channel. Each channel keeps first-in first-out order.
- R5: A 24-bit sample is returned sign-extended to 32 bits: bits 31:24 copy sample bit 23.
- R6: A data read from an empty queue returns zero and leaves that queue's count at zero.
- R7: Each queue holds 128 samples. A sample that arrives while its queue is full is discarded, the count stays at 128, and the samples already stored are kept.
- R8: A write to word 0 with bit 2 set empties both queues in one cycle. A write to word 0 without bit 2, or a write to any other word, changes nothing.
- R9: When a sample arrives in the same cycle as a data read of the same channel on a non-empty queue, both take effect and the count is unchanged.
- R10: A read of word 0 returns zero and removes no sample.
- R11: The read data output holds its value through cycles with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address of the register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| left_valid | input | 1 | Left sample strobe |
| left_sample | input | 24 | Left sample value |
| right_valid | input | 1 | Right sample strobe |
| right_sample | input | 24 | Right sample value |

## Verification
A wrong pointer or count inside a queue is visible at the ports on the next occupancy read or data read. It shows up as a count off by one, a sample returned out of order, or a stale value after a clear. The bench keeps its own queues and predicts the read data for every cycle, so any divergence is reported in the cycle after the read that exposes it. Long fill and drain runs push the pointers across the wrap point and into saturation. A mixed traffic phase issues arrivals, reads and clears in the same cycles, which exposes errors in simultaneous updates.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int BUS_W   = 32;
  localparam int FIELD_W = 8;
  localparam int CLR_BIT = 2;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_SPACE = 2'd1,
    SEL_LEFT  = 2'd2,
    SEL_RIGHT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  q,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && !clr && (level != CW'(DEPTH));
  assign pop_ok  = pop && !clr && (level != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (pop && !clr) begin
      q <= pop_ok ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      level <= level + CW'(push_ok) - CW'(pop_ok);
    end
  end

  a_r7_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
    (level == CW'(DEPTH) && push && !pop && !clr) |=> level == CW'(DEPTH));
  a_r6_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && pop && !push && !clr) |=> (q == '0 && level == '0));
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> level == '0);
  a_r9_pushpop_level: assert property (@(posedge clk) disable iff (rst)
    (level != '0 && level != CW'(DEPTH) && push && pop && !clr) |=> $stable(level));
  a_r4_pop_drops_one: assert property (@(posedge clk) disable iff (rst)
    (level != '0 && pop && !push && !clr) |=> level == $past(level) - 1'b1);
endmodule

// File: rtl/rx_read_mux.sv
module rx_read_mux
  import audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  reg_sel_e                sel,
  input  logic [BUS_W-1:0]        space_word,
  input  logic [SAMPLE_W-1:0]     left_q,
  input  logic [SAMPLE_W-1:0]     right_q,
  output logic [BUS_W-1:0]        rdata
);
  localparam int EXT_W = BUS_W - SAMPLE_W;

  always_comb begin
    unique case (sel)
      SEL_SPACE: rdata = space_word;
      SEL_LEFT:  rdata = {{EXT_W{left_q[SAMPLE_W-1]}}, left_q};
      SEL_RIGHT: rdata = {{EXT_W{right_q[SAMPLE_W-1]}}, right_q};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_rx_port.sv
module audio_rx_port
  import audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int DEPTH    = 128,
  parameter int TX_FREE  = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                left_valid,
  input  logic [SAMPLE_W-1:0] left_sample,
  input  logic                right_valid,
  input  logic [SAMPLE_W-1:0] right_sample
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NCHAN = 2;

  // channel 0 = right, channel 1 = left (matches occupancy byte order)
  logic [NCHAN-1:0]               ch_push, ch_pop;
  logic [NCHAN-1:0][SAMPLE_W-1:0] ch_din, ch_q;
  logic [NCHAN-1:0][CW-1:0]       ch_level;
  logic                           clr;
  reg_sel_e                       sel_q;
  logic [BUS_W-1:0]               space_q, space_now;
  logic                           wdata_unused;

  assign wdata_unused = ^{bus_wdata[BUS_W-1:CLR_BIT+1], bus_wdata[CLR_BIT-1:0]};

  assign clr = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL) && bus_wdata[CLR_BIT];

  assign ch_push = {left_valid, right_valid};
  assign ch_din  = {left_sample, right_sample};
  assign ch_pop  = {bus_rd && (reg_sel_e'(bus_addr) == SEL_LEFT),
                    bus_rd && (reg_sel_e'(bus_addr) == SEL_RIGHT)};

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .push  (ch_push[c]),
      .din   (ch_din[c]),
      .pop   (ch_pop[c]),
      .q     (ch_q[c]),
      .level (ch_level[c])
    );
  end

  assign space_now = {FIELD_W'(TX_FREE), FIELD_W'(TX_FREE),
                      FIELD_W'(ch_level[1]), FIELD_W'(ch_level[0])};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= SEL_CTRL;
      space_q <= '0;
    end else if (bus_rd) begin
      sel_q <= reg_sel_e'(bus_addr);
      if (reg_sel_e'(bus_addr) == SEL_SPACE) space_q <= space_now;
    end
  end

  rx_read_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .sel        (sel_q),
    .space_word (space_q),
    .left_q     (ch_q[1]),
    .right_q    (ch_q[0]),
    .rdata      (bus_rdata)
  );

  a_r2_space_counts: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd1) |=>
      bus_rdata[15:0] == {FIELD_W'($past(ch_level[1])), FIELD_W'($past(ch_level[0]))});
  a_r10_ctrl_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd0) |=> bus_rdata == '0);
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd && !$past(rst)) |=> $stable(bus_rdata));
  a_r10_ctrl_no_pop: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd0 && !left_valid && !right_valid) |=> $stable(ch_level));
endmodule

// File: tb/audio_rx_port_test.sv
module audio_rx_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        left_valid = 1'b0, right_valid = 1'b0;
  logic [23:0] left_sample = '0, right_sample = '0;

  audio_rx_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .left_valid(left_valid), .left_sample(left_sample),
    .right_valid(right_valid), .right_sample(right_sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit    done = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural reference model
  logic [23:0] lq[$], rq[$];
  logic [31:0] exp_rdata = '0;
  bit          model_live = 1'b0;

  function automatic logic [31:0] sx(input logic [23:0] s);
    return {{8{s[23]}}, s};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      lq.delete(); rq.delete();
      exp_rdata  = '0;
      model_live = 1'b1;
    end else begin
      int  lpre, rpre;
      bit  clear;
      lpre  = lq.size();
      rpre  = rq.size();
      clear = bus_wr && bus_addr == 2'd0 && bus_wdata[2];
      if (bus_rd) begin
        case (bus_addr)
          2'd0: exp_rdata = '0;
          2'd1: exp_rdata = {8'd128, 8'd128, 8'(lpre), 8'(rpre)};
          2'd2: exp_rdata = (lpre > 0) ? sx(lq.pop_front()) : '0;
          default: exp_rdata = (rpre > 0) ? sx(rq.pop_front()) : '0;
        endcase
      end
      if (clear) begin
        lq.delete(); rq.delete();
      end else begin
        if (left_valid && lpre < DEPTH)  lq.push_back(left_sample);
        if (right_valid && rpre < DEPTH) rq.push_back(right_sample);
      end
    end
  end

  always @(negedge clk) begin
    if (model_live) chk(phase, bus_rdata, exp_rdata);
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic step(input logic rd, input logic [1:0] a, input logic wr,
                      input logic [31:0] wd, input logic lv, input logic [23:0] ls,
                      input logic rv, input logic [23:0] rs);
    bus_rd = rd; bus_addr = a; bus_wr = wr; bus_wdata = wd;
    left_valid = lv; left_sample = ls; right_valid = rv; right_sample = rs;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 2'd0, 0, '0, 0, '0, 0, '0);
  endtask

  task automatic rd_reg(input logic [1:0] a);
    step(1, a, 0, '0, 0, '0, 0, '0);
  endtask

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    chk("R1", bus_rdata, 32'h0);
    rd_reg(2'd1);
    chk("R1 counts zero", bus_rdata[15:0], 16'h0);
    chk("R3", bus_rdata[31:16], 16'h8080);

    phase = "R4";
    step(0, 0, 0, 0, 1, 24'h000123, 1, 24'h800000);
    step(0, 0, 0, 0, 1, 24'hFFFFFE, 1, 24'h000010);
    step(0, 0, 0, 0, 1, 24'h7FFFFF, 0, 24'h0);
    rd_reg(2'd1); chk("R2", bus_rdata, 32'h8080_0302);
    rd_reg(2'd2); chk("R4 left oldest", bus_rdata, 32'h0000_0123);
    rd_reg(2'd3); chk("R5 negative right", bus_rdata, 32'hFF80_0000);
    rd_reg(2'd2); chk("R5 negative left", bus_rdata, 32'hFFFF_FFFE);
    rd_reg(2'd1); chk("R2 after pops", bus_rdata, 32'h8080_0101);
    rd_reg(2'd2); chk("R5 positive", bus_rdata, 32'h007F_FFFF);
    rd_reg(2'd3); chk("R4 right order", bus_rdata, 32'h0000_0010);

    phase = "R6";
    rd_reg(2'd2); chk("R6 empty left", bus_rdata, 32'h0);
    rd_reg(2'd3); chk("R6 empty right", bus_rdata, 32'h0);
    rd_reg(2'd1); chk("R6 counts stay zero", bus_rdata, 32'h8080_0000);

    phase = "R10";
    step(0, 0, 0, 0, 1, 24'h000005, 0, 0);
    rd_reg(2'd1); chk("R10 pre", bus_rdata, 32'h8080_0100);
    rd_reg(2'd0); chk("R10 ctrl read", bus_rdata, 32'h0);
    rd_reg(2'd1); chk("R10 no pop", bus_rdata, 32'h8080_0100);

    phase = "R11";
    repeat (4) idle();
    chk("R11 hold", bus_rdata, 32'h8080_0100);

    phase = "R7";
    for (int i = 0; i < 130; i++) step(0, 0, 0, 0, 1, 24'(i + 'h100), 0, 0);
    rd_reg(2'd1); chk("R7 saturate", bus_rdata, 32'h8080_8000);
    step(0, 0, 0, 0, 1, 24'hABCDEF, 0, 0);
    rd_reg(2'd1); chk("R7 still full", bus_rdata, 32'h8080_8000);
    rd_reg(2'd2); chk("R7 kept oldest", bus_rdata, 32'h0000_0005);
    rd_reg(2'd2); chk("R7 order", bus_rdata, 32'h0000_0100);

    phase = "R9";
    rd_reg(2'd1); snap = bus_rdata;
    step(1, 2'd2, 0, 0, 1, 24'h0A0A0A, 0, 0);
    chk("R9 pop data", bus_rdata, 32'h0000_0101);
    rd_reg(2'd1); chk("R9 level same", bus_rdata, snap);

    phase = "R8";
    step(0, 0, 0, 0, 0, 0, 1, 24'h000777);
    rd_reg(2'd1); snap = bus_rdata;
    step(0, 2'd0, 1, 32'hFFFF_FFFB, 0, 0, 0, 0);
    rd_reg(2'd1); chk("R8 no clear without bit", bus_rdata, snap);
    step(0, 2'd1, 1, 32'h0000_0004, 0, 0, 0, 0);
    rd_reg(2'd1); chk("R8 no clear other word", bus_rdata, snap);
    step(0, 2'd0, 1, 32'h0000_0004, 0, 0, 0, 0);
    rd_reg(2'd1); chk("R8 cleared", bus_rdata, 32'h8080_0000);
    rd_reg(2'd2); chk("R8 left empty", bus_rdata, 32'h0);
    step(0, 0, 0, 0, 1, 24'h000042, 1, 24'h000043);
    rd_reg(2'd3); chk("R8 usable after clear", bus_rdata, 32'h0000_0043);

    phase = "R9 mixed";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], (r[11:4] == 8'h00), {29'h0, r[12], 2'b00},
           r[13] | r[14], r[31:8], r[15] | r[16], r[23:0]);
    end
    idle();
    finish_run();
  end
endmodule